// File: doc/BRIEF.md
# Powered-Device Pass-Switch Sequencer

This controller decides when the pass switch of a powered device conducts and which current limit the analog regulator applies. It watches synchronized comparator flags: input above the undervoltage threshold, switch current below ninety percent of the inrush limit, return node above about 12 V, auxiliary supply present, external disable, and over-temperature. From these it drives a switch enable, a limit select, an active-low converter-disable and an inrush-active flag.

Each time the switch turns on it starts in the low inrush limit and holds the downstream converter disabled. When the current sense shows that the bulk capacitor has charged, the controller moves to the operational limit and releases the converter. A return-node overload that persists for a programmable number of clock cycles (about 800 µs at the system clock) folds the switch back to inrush mode. Any forcing condition turns the switch off, and every restart goes through inrush again. The current regulation itself is analog and lies outside this block.

Top module: `hs_seq_ctl`

## Requirements
- R1: While `rst` is sampled high, the outputs become sw_en=0, lim_op=0, cdb_n=0 and inrush_act=1.
- R2: When any of uvlo_ok=0, aux_det=1, dis_req=1 or over_temp=1 is sampled at an edge, the outputs after that edge are sw_en=0, lim_op=0, cdb_n=1 and inrush_act=0, whatever the present state.
- R3: When the switch is off and no forcing condition is sampled, the next edge turns it on in inrush mode (sw_en=1, lim_op=0), even if i_below90 is high.
- R4: cdb_n is 0 exactly while the switch is on in inrush mode, and also during reset; it is 1 otherwise. inrush_act equals the inverse of cdb_n in every cycle.
- R5: In inrush mode, i_below90 sampled high with no forcing condition moves the switch to operational mode (lim_op=1, cdb_n=1) at that edge. While i_below90 stays low, inrush mode holds.
- R6: In operational mode, rtn_high sampled high on DG_CYC consecutive edges returns the switch to inrush mode at the last of those edges. After DG_CYC-1 such edges it is still in operational mode.
- R7: One edge with rtn_high low in operational mode clears the overload count, so a full DG_CYC further edges are needed before foldback.
- R8: rtn_high has no effect in inrush mode and adds nothing to the overload count carried into operational mode.
- R9: After a forcing condition ends (over-temperature held for several cycles included), the switch restarts in inrush mode and never directly in operational mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo_ok | input | 1 | Input is above the lockout threshold (hysteresis is applied upstream) |
| i_below90 | input | 1 | Switch current is below 90% of the inrush limit |
| rtn_high | input | 1 | Return node is above about 12 V |
| aux_det | input | 1 | Auxiliary supply detected; forces the switch off |
| dis_req | input | 1 | External disable request; forces the switch off |
| over_temp | input | 1 | Over-temperature flag (hysteretic); forces the switch off |
| sw_en | output | 1 | Pass switch enable |
| lim_op | output | 1 | Limit select: 0 selects the inrush limit, 1 the operational limit |
| cdb_n | output | 1 | Converter disable, active low (1 = released) |
| inrush_act | output | 1 | High exactly when cdb_n is low |

## Verification
Every output is registered from the state of the present cycle and the flags sampled at the same edge. A change in an input therefore shows at the outputs one edge later, and foldback shows at the DG_CYC-th consecutive overload edge. The bench changes the inputs on the falling edge, lets exactly one rising edge pass for each step, and reads the outputs at the following falling edge. It checks the cycle just before each expected transition as well as the cycle of the transition.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_INR = 2'd1,
    ST_OPR = 2'd2
  } hs_state_t;
endpackage

// File: rtl/hs_gate.sv
// Merges every condition that must hold the pass switch open.
module hs_gate (
  input  logic uvlo_ok,
  input  logic aux_det,
  input  logic dis_req,
  input  logic over_temp,
  output logic force_off
);
  always_comb force_off = !uvlo_ok || aux_det || dis_req || over_temp;
endmodule

// File: rtl/hs_deglitch.sv
// Counts consecutive overload edges while armed; expire fires on the LIM-th one.
module hs_deglitch #(
  parameter int LIM = 160000,
  parameter int CW  = $clog2(LIM + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic hi,
  output logic expire
);
  localparam logic [CW-1:0] LAST = CW'(LIM - 1);

  logic [CW-1:0] cnt_q;

  always_comb expire = arm && hi && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !arm || !hi || expire) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hs_fsm.sv
// State register plus registered outputs taken from the next state.
module hs_fsm
  import hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      force_off,
  input  logic      cur_low,
  input  logic      expire,
  output hs_state_t state_o,
  output logic      sw_en,
  output logic      lim_op,
  output logic      cdb_n,
  output logic      inrush_act
);
  hs_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (force_off) st_d = ST_OFF;
    else begin
      unique case (st_q)
        ST_OFF:  st_d = ST_INR;
        ST_INR:  if (cur_low) st_d = ST_OPR;
        ST_OPR:  if (expire)  st_d = ST_INR;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_OFF;
      sw_en      <= 1'b0;
      lim_op     <= 1'b0;
      cdb_n      <= 1'b0;
      inrush_act <= 1'b1;
    end else begin
      st_q       <= st_d;
      sw_en      <= (st_d != ST_OFF);
      lim_op     <= (st_d == ST_OPR);
      cdb_n      <= (st_d != ST_INR);
      inrush_act <= (st_d == ST_INR);
    end
  end

  always_comb state_o = st_q;
endmodule

// File: rtl/hs_seq_ctl.sv
module hs_seq_ctl
  import hs_pkg::*;
#(
  parameter int DG_CYC = 160000
) (
  input  logic clk,
  input  logic rst,
  input  logic uvlo_ok,
  input  logic i_below90,
  input  logic rtn_high,
  input  logic aux_det,
  input  logic dis_req,
  input  logic over_temp,
  output logic sw_en,
  output logic lim_op,
  output logic cdb_n,
  output logic inrush_act
);
  localparam int CW = $clog2(DG_CYC + 1);

  logic      force_off;
  logic      expire;
  logic      arm;
  hs_state_t state;

  hs_gate u_gate (
    .uvlo_ok   (uvlo_ok),
    .aux_det   (aux_det),
    .dis_req   (dis_req),
    .over_temp (over_temp),
    .force_off (force_off)
  );

  always_comb arm = (state == ST_OPR) && !force_off;

  hs_deglitch #(.LIM(DG_CYC), .CW(CW)) u_dg (
    .clk    (clk),
    .rst    (rst),
    .arm    (arm),
    .hi     (rtn_high),
    .expire (expire)
  );

  hs_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .force_off  (force_off),
    .cur_low    (i_below90),
    .expire     (expire),
    .state_o    (state),
    .sw_en      (sw_en),
    .lim_op     (lim_op),
    .cdb_n      (cdb_n),
    .inrush_act (inrush_act)
  );
endmodule

// File: rtl/hs_seq_chk.sv
module hs_seq_chk (
  input logic clk,
  input logic rst,
  input logic uvlo_ok,
  input logic i_below90,
  input logic aux_det,
  input logic dis_req,
  input logic over_temp,
  input logic sw_en,
  input logic lim_op,
  input logic cdb_n,
  input logic inrush_act
);
  logic frc;
  always_comb frc = !uvlo_ok || aux_det || dis_req || over_temp;

  p_forced_off_r2: assert property (@(posedge clk) disable iff (rst)
    frc |=> (!sw_en && !lim_op && cdb_n));

  p_start_inrush_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en) |-> (!lim_op && !cdb_n));

  p_flag_mirror_r4: assert property (@(posedge clk) disable iff (rst)
    inrush_act == !cdb_n);

  p_cdb_off_r4: assert property (@(posedge clk) disable iff (rst)
    (!sw_en && !$past(rst)) |-> cdb_n);

  p_oper_needs_on_r4: assert property (@(posedge clk) disable iff (rst)
    lim_op |-> (sw_en && cdb_n));

  p_handover_r5: assert property (@(posedge clk) disable iff (rst)
    (sw_en && !lim_op && i_below90 && !frc) |=> lim_op);

  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (!sw_en && !frc) |=> (sw_en && !lim_op));
endmodule

bind hs_seq_ctl hs_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .uvlo_ok    (uvlo_ok),
  .i_below90  (i_below90),
  .aux_det    (aux_det),
  .dis_req    (dis_req),
  .over_temp  (over_temp),
  .sw_en      (sw_en),
  .lim_op     (lim_op),
  .cdb_n      (cdb_n),
  .inrush_act (inrush_act)
);

// File: tb/sim_hs_seq_ctl.sv
`timescale 1ns/1ps
module sim_hs_seq_ctl;
  localparam int DG = 8;
  // packed {sw_en, lim_op, cdb_n, inrush_act}
  localparam logic [3:0] E_RST = 4'b0001;
  localparam logic [3:0] E_OFF = 4'b0010;
  localparam logic [3:0] E_INR = 4'b1001;
  localparam logic [3:0] E_OPR = 4'b1110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uvlo_ok = 1'b0, i_below90 = 1'b0, rtn_high = 1'b0;
  logic aux_det = 1'b0, dis_req = 1'b0, over_temp = 1'b0;
  logic sw_en, lim_op, cdb_n, inrush_act;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hs_seq_ctl #(.DG_CYC(DG)) u0 (
    .clk(clk), .rst(rst), .uvlo_ok(uvlo_ok), .i_below90(i_below90),
    .rtn_high(rtn_high), .aux_det(aux_det), .dis_req(dis_req),
    .over_temp(over_temp), .sw_en(sw_en), .lim_op(lim_op),
    .cdb_n(cdb_n), .inrush_act(inrush_act)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, logic [3:0] exp);
    logic [3:0] got;
    got = {sw_en, lim_op, cdb_n, inrush_act};
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic to_oper();
    {aux_det, dis_req, over_temp, rtn_high} = '0;
    uvlo_ok = 1'b0; tick();
    uvlo_ok = 1'b1; i_below90 = 1'b0; tick();
    i_below90 = 1'b1; tick();
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(2);
    chk("R1 reset state", E_RST);
    rst = 1'b0;
  endtask

  task automatic t_startup();
    uvlo_ok = 1'b0; tick();
    chk("R2 lockout holds off", E_OFF);
    chk_r4_off: chk("R4 cdb released when off", E_OFF);
    uvlo_ok = 1'b1; i_below90 = 1'b1; tick();
    chk("R3 first enable is inrush", E_INR);
    tick();
    chk("R5 handover with i_below90 high", E_OPR);
  endtask

  task automatic t_handover();
    uvlo_ok = 1'b0; tick();
    uvlo_ok = 1'b1; i_below90 = 1'b0; tick(3);
    chk("R4 inrush holds, cdb low", E_INR);
    i_below90 = 1'b1; tick();
    chk("R5 operational after current drop", E_OPR);
  endtask

  task automatic t_foldback();
    to_oper();
    i_below90 = 1'b0; rtn_high = 1'b1; tick(DG - 1);
    chk("R6 still operational one edge early", E_OPR);
    tick();
    chk("R6 foldback to inrush", E_INR);
    rtn_high = 1'b0;
  endtask

  task automatic t_break();
    to_oper();
    rtn_high = 1'b1; tick(5);
    rtn_high = 1'b0; tick();
    chk("R7 gap keeps operational", E_OPR);
    rtn_high = 1'b1; tick(DG - 1);
    chk("R7 count restarted after gap", E_OPR);
    tick();
    chk("R7 foldback after full window", E_INR);
    rtn_high = 1'b0;
  endtask

  task automatic t_inrush_rtn();
    uvlo_ok = 1'b0; tick();
    uvlo_ok = 1'b1; i_below90 = 1'b0; rtn_high = 1'b1; tick(DG + 2);
    chk("R8 overload ignored in inrush", E_INR);
    i_below90 = 1'b1; tick();
    chk("R8 handover despite overload", E_OPR);
    tick(DG - 1);
    chk("R8 no count carried from inrush", E_OPR);
    rtn_high = 1'b0; tick();
  endtask

  task automatic t_force();
    to_oper(); aux_det = 1'b1; tick();
    chk("R2 aux detect forces off", E_OFF);
    aux_det = 1'b0; tick();
    chk("R9 restart after aux in inrush", E_INR);
    to_oper(); dis_req = 1'b1; tick();
    chk("R2 disable request forces off", E_OFF);
    dis_req = 1'b0;
    to_oper(); uvlo_ok = 1'b0; tick();
    chk("R2 lockout from operational", E_OFF);
    to_oper(); over_temp = 1'b1; tick(4);
    chk("R2 over-temp holds off", E_OFF);
    i_below90 = 1'b1; over_temp = 1'b0; tick();
    chk("R9 restart after over-temp in inrush", E_INR);
    tick();
    chk("R9 then operational", E_OPR);
    rst = 1'b1; tick();
    chk("R1 reset from operational", E_RST);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_startup();
    t_handover();
    t_foldback();
    t_break();
    t_inrush_rtn();
    t_force();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: done=0 expected=1");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule